// File: doc/BRIEF.md
# Microprogrammed Accumulator CPU Sequencer

This block is the control and data core of a small 12-bit accumulator machine. Each instruction word carries a 4-bit opcode in bits 11:8 and an 8-bit operand address in bits 7:0. A micro-program counter steps through a 256-entry control store. Each 28-bit control word carries 17 data-path strobes: four ALU controls, three memory commands, a one-hot A-bus source select, a B-bus accumulator enable and five C-bus load enables. It also holds a dispatch bit, a 2-bit jump kind and an 8-bit next micro-address. When dispatch is set, the next micro-address is the opcode followed by four zero bits. Jump kind 00 steps to the next micro-address. Kind 01 jumps when the latched P (non-negative) flag is set, kind 10 when the latched Z flag is set, and kind 11 always.

The core holds its own MAR, MDR, ACC, PC and IR and talks to an external word memory. The memory sees `memAddr`, which is the MAR, and returns `memRdData` combinationally. The MDR captures that data at the end of the cycle after a read command. A write command loads the MDR and asks the memory to write `memWrData` to `memAddr` at the end of the following cycle. Fetch takes three cycles: the PC goes to the MAR with a read, the PC is incremented while memory waits, then the MDR goes to the IR with dispatch. Because the IR is loaded in that same cycle, the opcode used for dispatch is taken from the C-bus. Opcode 0 stops the machine until reset. The `retired` output marks the last cycle of every completed instruction, so that cycle counts can be observed.

Top module: `mcpu_core`

## Requirements
- R1: After reset `halted` and `retired` are low, ACC is zero, and in the first cycle `memRd` is high with `memAddr` equal to 0, so execution starts at address 0.
- R2: Opcode 1 adds and opcode 2 subtracts the memory word at the address field to or from ACC, wrapping modulo 2^12. Each takes 6 cycles.
- R3: Opcode 5 loads the memory word into ACC in 6 cycles. Opcode 3 writes ACC to the address field in 6 cycles and leaves ACC unchanged.
- R4: Opcode 6 loads the 8-bit address field into PC and completes in 4 cycles.
- R5: Opcode 7 branches when ACC is zero and otherwise falls through. It takes 5 cycles either way and leaves ACC unchanged.
- R6: Opcode 8 branches when ACC bit 11 is 0, zero included, and otherwise falls through. It takes 5 cycles either way.
- R7: Opcode 0 raises `halted` at the end of its third fetch cycle. `halted` then stays high with no memory command and no `retired` pulse until reset, and reset restarts execution at address 0.
- R8: Opcodes 4 and 9 to 15 act as no-ops of 4 cycles that leave ACC and memory untouched.
- R9: `retired` is a one-cycle pulse in the last cycle of each non-halt instruction, one per instruction.
- R10: Read data is captured in the cycle after `memRd`, and the write happens in the cycle after `memWr`. `memRd` and `memWr` are never high together or in consecutive cycles, and `memPd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| memRdData | input | 12 | Word at `memAddr`, from memory |
| memAddr | output | 8 | Memory address (MAR) |
| memWrData | output | 12 | Write data (MDR) |
| memRd | output | 1 | Read command this cycle |
| memWr | output | 1 | Write command this cycle |
| memPd | output | 1 | Presence-detect command this cycle |
| halted | output | 1 | Machine stopped by opcode 0 |
| retired | output | 1 | Last cycle of an instruction |

## Verification
The bench targets sign and wrap corners: 0x7FF plus 1 and 0x800 minus 1. A core that carried or saturated would store a wrong word. It runs both conditional branches with ACC zero and with ACC negative. A design that tested bit 11 for zero, or that used a stale flag, would branch the wrong way or take a different number of cycles. It times every instruction by the gap between `retired` pulses, so a missing wait state or a misplaced read capture shows up as a wrong latency or wrong data. It also runs a program a second time after halt without reloading it, which exposes a halt that does not stick or a reset that does not restart at address 0.

// File: rtl/mcpu_pkg.sv
`timescale 1ns/1ps
package mcpu_pkg;
  localparam int OP_W  = 4;
  localparam int UPC_W = 8;

  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h2;
  localparam logic [OP_W-1:0] OP_STORE = 4'h3;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [OP_W-1:0] OP_BR    = 4'h6;
  localparam logic [OP_W-1:0] OP_BRZ   = 4'h7;
  localparam logic [OP_W-1:0] OP_BRP   = 4'h8;

  // A-bus source bits (one-hot)
  localparam int A_MDR = 0;
  localparam int A_ACC = 1;
  localparam int A_PC  = 2;
  localparam int A_IR  = 3;
  // C-bus destination bits
  localparam int C_MAR = 0;
  localparam int C_MDR = 1;
  localparam int C_ACC = 2;
  localparam int C_PC  = 3;
  localparam int C_IR  = 4;

  typedef enum logic [1:0] {
    J_SEQ = 2'b00, J_POS = 2'b01, J_ZERO = 2'b10, J_ALWAYS = 2'b11
  } jmpKind_t;

  // 17 data-path strobes
  typedef struct packed {
    logic       enaA;
    logic       invA;
    logic       enaB;
    logic       inc;
    logic       rd;
    logic       wr;
    logic       pd;
    logic [3:0] aSel;
    logic       bAcc;
    logic [4:0] cEn;
  } dpCtrl_t;

  // 28-bit control word
  typedef struct packed {
    dpCtrl_t          dp;
    logic             dispatch;
    jmpKind_t         jmp;
    logic [UPC_W-1:0] nextAddr;
  } uWord_t;
endpackage

// File: rtl/mcpu_ustore.sv
`timescale 1ns/1ps
module mcpu_ustore
  import mcpu_pkg::*;
(
  input  logic [UPC_W-1:0] uAddr,
  output uWord_t           word
);
  // Every address not listed returns to fetch at 0x00.
  always_comb begin
    word = '0;
    word.jmp = J_ALWAYS;
    word.nextAddr = '0;
    case (uAddr)
      8'h00: begin
        word.jmp = J_SEQ;
        word.dp.aSel[A_PC] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.cEn[C_MAR] = 1'b1; word.dp.rd = 1'b1;
      end
      8'h01: begin
        word.jmp = J_SEQ;
        word.dp.aSel[A_PC] = 1'b1; word.dp.enaA = 1'b1; word.dp.inc = 1'b1;
        word.dp.cEn[C_PC] = 1'b1;
      end
      8'h02: begin
        word.jmp = J_SEQ; word.dispatch = 1'b1;
        word.dp.aSel[A_MDR] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.cEn[C_IR] = 1'b1;
      end
      {OP_ADD, 4'h0}, {OP_SUB, 4'h0}, {OP_LOAD, 4'h0}, {OP_STORE, 4'h0}: begin
        word.jmp = J_SEQ;
        word.dp.aSel[A_IR] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.cEn[C_MAR] = 1'b1;
        word.dp.rd = (uAddr[7:4] != OP_STORE);
      end
      {OP_ADD, 4'h1}, {OP_SUB, 4'h1}, {OP_LOAD, 4'h1}: word.jmp = J_SEQ;
      {OP_ADD, 4'h2}: begin
        word.dp.aSel[A_MDR] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.bAcc = 1'b1; word.dp.enaB = 1'b1;
        word.dp.cEn[C_ACC] = 1'b1;
      end
      {OP_SUB, 4'h2}: begin
        word.dp.aSel[A_MDR] = 1'b1; word.dp.enaA = 1'b1; word.dp.invA = 1'b1;
        word.dp.inc = 1'b1;
        word.dp.bAcc = 1'b1; word.dp.enaB = 1'b1;
        word.dp.cEn[C_ACC] = 1'b1;
      end
      {OP_LOAD, 4'h2}: begin
        word.dp.aSel[A_MDR] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.cEn[C_ACC] = 1'b1;
      end
      {OP_STORE, 4'h1}: begin
        word.jmp = J_SEQ;
        word.dp.bAcc = 1'b1; word.dp.enaB = 1'b1;
        word.dp.cEn[C_MDR] = 1'b1; word.dp.wr = 1'b1;
      end
      {OP_BR, 4'h0}, {OP_BRZ, 4'h2}, {OP_BRP, 4'h2}: begin
        word.dp.aSel[A_IR] = 1'b1; word.dp.enaA = 1'b1;
        word.dp.cEn[C_PC] = 1'b1;
      end
      {OP_BRZ, 4'h0}: begin
        word.jmp = J_ZERO; word.nextAddr = {OP_BRZ, 4'h2};
      end
      {OP_BRP, 4'h0}: begin
        word.jmp = J_POS; word.nextAddr = {OP_BRP, 4'h2};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcpu_seq.sv
`timescale 1ns/1ps
module mcpu_seq
  import mcpu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opNext,
  input  logic            flagP,
  input  logic            flagZ,
  output dpCtrl_t         ctrl,
  output logic            halted,
  output logic            retired
);
  logic [UPC_W-1:0] upc, nextUpc, upcInc;
  uWord_t           word;
  logic             haltNow;

  mcpu_ustore u_store (.uAddr(upc), .word(word));

  assign upcInc = upc + 1'b1;

  always_comb begin
    case (word.jmp)
      J_POS:    nextUpc = flagP ? word.nextAddr : upcInc;
      J_ZERO:   nextUpc = flagZ ? word.nextAddr : upcInc;
      J_ALWAYS: nextUpc = word.nextAddr;
      default:  nextUpc = upcInc;
    endcase
    if (word.dispatch) nextUpc = {opNext, {(UPC_W-OP_W){1'b0}}};
  end

  assign haltNow = word.dispatch && (opNext == OP_HALT) && !halted;
  assign ctrl    = halted ? '0 : word.dp;
  assign retired = !halted && !haltNow && (nextUpc == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upc    <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      upc <= nextUpc;
      if (haltNow) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/mcpu_dp.sv
`timescale 1ns/1ps
module mcpu_dp
  import mcpu_pkg::*;
#(
  parameter int WordW = 12,
  parameter int AddrW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [WordW-1:0] memRdData,
  output logic [AddrW-1:0] memAddr,
  output logic [WordW-1:0] memWrData,
  output logic [OP_W-1:0]  opNext,
  output logic             flagP,
  output logic             flagZ
);
  localparam int PadW = WordW - AddrW;

  logic [AddrW-1:0] mar, pc;
  logic [WordW-1:0] mdr, acc, ir;
  logic [WordW-1:0] aBus, aluA, aluB, cBus;
  logic             rdPend;

  // One-hot OR mux onto the A-bus; IR and PC are zero-filled.
  always_comb begin
    aBus = '0;
    if (ctrl.aSel[A_MDR]) aBus = aBus | mdr;
    if (ctrl.aSel[A_ACC]) aBus = aBus | acc;
    if (ctrl.aSel[A_PC])  aBus = aBus | {{PadW{1'b0}}, pc};
    if (ctrl.aSel[A_IR])  aBus = aBus | {{PadW{1'b0}}, ir[AddrW-1:0]};
  end

  assign aluA = (ctrl.enaA ? aBus : '0) ^ {WordW{ctrl.invA}};
  assign aluB = (ctrl.enaB && ctrl.bAcc) ? acc : '0;
  assign cBus = aluA + aluB + {{(WordW-1){1'b0}}, ctrl.inc};

  // Dispatch sees the opcode being loaded into IR this cycle.
  assign opNext    = ctrl.cEn[C_IR] ? cBus[WordW-1 -: OP_W] : ir[WordW-1 -: OP_W];
  assign memAddr   = mar;
  assign memWrData = mdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mar <= '0; pc <= '0; mdr <= '0; acc <= '0; ir <= '0;
      rdPend <= 1'b0; flagP <= 1'b1; flagZ <= 1'b1;
    end else begin
      rdPend <= ctrl.rd;
      if (rdPend)              mdr <= memRdData;
      else if (ctrl.cEn[C_MDR]) mdr <= cBus;
      if (ctrl.cEn[C_MAR]) mar <= cBus[AddrW-1:0];
      if (ctrl.cEn[C_PC])  pc  <= cBus[AddrW-1:0];
      if (ctrl.cEn[C_IR])  ir  <= cBus;
      if (ctrl.cEn[C_ACC]) begin
        acc   <= cBus;
        flagP <= !cBus[WordW-1];
        flagZ <= (cBus == '0);
      end
    end
  end
endmodule

// File: rtl/mcpu_core.sv
`timescale 1ns/1ps
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int WordW = 12,
  parameter int AddrW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WordW-1:0] memRdData,
  output logic [AddrW-1:0] memAddr,
  output logic [WordW-1:0] memWrData,
  output logic             memRd,
  output logic             memWr,
  output logic             memPd,
  output logic             halted,
  output logic             retired
);
  dpCtrl_t         ctrlBus;
  logic [OP_W-1:0] opNext;
  logic            flagP, flagZ;

  mcpu_seq u_seq (
    .clk(clk), .rstN(rstN), .opNext(opNext), .flagP(flagP), .flagZ(flagZ),
    .ctrl(ctrlBus), .halted(halted), .retired(retired)
  );

  mcpu_dp #(.WordW(WordW), .AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .opNext(opNext),
    .flagP(flagP), .flagZ(flagZ)
  );

  assign memRd = ctrlBus.rd;
  assign memWr = ctrlBus.wr;
  assign memPd = ctrlBus.pd;
endmodule

// File: rtl/mcpu_core_chk.sv
`timescale 1ns/1ps
module mcpu_core_chk
  import mcpu_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input dpCtrl_t ctrl,
  input logic    halted,
  input logic    retired,
  input logic    memRd,
  input logic    memWr
);
  assert_abus_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl.aSel));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memRd && !memWr && !retired));

  assert_retire_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    retired |=> !retired);

  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_mem_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |=> !(memRd || memWr));
endmodule

bind mcpu_core mcpu_core_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .halted(halted),
  .retired(retired), .memRd(memRd), .memWr(memWr)
);

// File: tb/mcpu_core_bench.sv
`timescale 1ns/1ps
module mcpu_core_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memRdData, memWrData;
  logic [7:0]  memAddr;
  logic        memRd, memWr, memPd, halted, retired;
  logic        wrPend = 1'b0;
  logic [11:0] mem [256];
  logic [11:0] refMem [256];
  int          expLat [1024];
  int          expOp  [1024];
  int          expN, expTotal;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mcpu_core u_mcpu_core (
    .clk(clk), .rstN(rstN), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .memRd(memRd), .memWr(memWr), .memPd(memPd),
    .halted(halted), .retired(retired)
  );

  // Memory model: combinational read, write one cycle after the command.
  assign memRdData = mem[memAddr];
  always @(posedge clk) begin
    wrPend <= memWr && rstN;
    if (wrPend) mem[memAddr] <= memWrData;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic string reqOf(input int op);
    case (op)
      1, 2:    return "R2";
      3, 5:    return "R3";
      6:       return "R4";
      7:       return "R5";
      8:       return "R6";
      0:       return "R7";
      default: return "R8";
    endcase
  endfunction

  // Instruction-level reference model over the current memory image.
  task automatic runIss();
    logic [11:0] m [256];
    logic [11:0] acc, ins;
    logic [7:0]  pc, a;
    int          op, lat;
    for (int i = 0; i < 256; i++) m[i] = mem[i];
    acc = '0; pc = '0; expN = 0; expTotal = 0;
    for (int s = 0; s < 1000; s++) begin
      ins = m[pc]; op = int'(ins[11:8]); a = ins[7:0]; pc = pc + 8'd1;
      if (op == 0) break;
      case (op)
        1: begin acc = acc + m[a]; lat = 6; end
        2: begin acc = acc - m[a]; lat = 6; end
        3: begin m[a] = acc; lat = 6; end
        5: begin acc = m[a]; lat = 6; end
        6: begin pc = a; lat = 4; end
        7: begin if (acc == 12'd0) pc = a; lat = 5; end
        8: begin if (!acc[11]) pc = a; lat = 5; end
        default: lat = 4;
      endcase
      expLat[expN] = lat; expOp[expN] = op; expN++; expTotal += lat;
    end
    for (int i = 0; i < 256; i++) refMem[i] = m[i];
  endtask

  task automatic runProgram(input string tag);
    int k, prev, idx, bad, mm, firstBad;
    runIss();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    k = 0; prev = -1; idx = 0; bad = 0;
    // R1: reset state seen in cycle 0
    check(!halted && !retired && memRd && memAddr == 8'h00, "R1", "reset state",
          {halted, retired, memRd}, 3'b001);
    while (!halted && k < 5000) begin
      if (memPd || (memRd && memWr)) bad++;
      if (retired) begin
        if (idx < expN)
          check(k - prev == expLat[idx], reqOf(expOp[idx]), "latency",
                k - prev, expLat[idx]);
        prev = k; idx++;
      end
      @(negedge clk); k++;
    end
    check(k == expTotal + 3, "R7", "halt cycle", k, expTotal + 3);
    check(idx == expN, "R9", "retire count", idx, expN);
    check(bad == 0, "R10", "command overlap or pd", bad, 0);
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (!halted || memRd || memWr || retired) bad++;
    end
    check(bad == 0, "R7", "halt not quiet", bad, 0);
    mm = 0; firstBad = 0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== refMem[i]) begin
        if (mm == 0) firstBad = i;
        mm++;
      end
    check(mm == 0, tag, "memory image", mem[firstBad], refMem[firstBad]);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 12'h000;
  endtask

  task automatic randProgram();
    int n, r, op;
    clearMem();
    for (int i = 8'hC0; i < 8'hD0; i++) mem[i] = 12'($urandom);
    n = 4 + int'($urandom % 16);
    for (int i = 0; i < n; i++) begin
      r = int'($urandom % 8);
      case (r)
        0: op = 1;
        1: op = 2;
        2: op = 3;
        3: op = 5;
        4: op = 6 + int'($urandom % 3);
        5: op = (($urandom % 2) == 0) ? 4 : 9 + int'($urandom % 7);
        default: op = 5;
      endcase
      if (op >= 6 && op <= 8)
        mem[i] = {4'(op), 8'(i + 1 + int'($urandom % (n - i)))};
      else
        mem[i] = {4'(op), 8'(8'hC0 + int'($urandom % 16))};
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearMem();

    // R1: ACC is zero after reset
    mem[0] = 12'h3C0; mem[1] = 12'h000; mem[8'hC0] = 12'h5A5;
    runProgram("R1");
    check(mem[8'hC0] == 12'h000, "R1", "ACC after reset", mem[8'hC0], 0);

    // R2: wrap at the sign boundary
    clearMem();
    mem[0] = 12'h5C0; mem[1] = 12'h1C1; mem[2] = 12'h3C2; mem[3] = 12'h2C1;
    mem[4] = 12'h3C3; mem[5] = 12'h5C4; mem[6] = 12'h2C1; mem[7] = 12'h3C5;
    mem[8] = 12'h000;
    mem[8'hC0] = 12'h7FF; mem[8'hC1] = 12'h001; mem[8'hC4] = 12'h800;
    runProgram("R2");
    check(mem[8'hC2] == 12'h800, "R2", "0x7FF+1", mem[8'hC2], 12'h800);
    check(mem[8'hC3] == 12'h7FF, "R2", "0x800-1 after add", mem[8'hC3], 12'h7FF);
    check(mem[8'hC5] == 12'h7FF, "R2", "0x800-1", mem[8'hC5], 12'h7FF);

    // R5 / R6: zero and negative accumulator
    clearMem();
    mem[0] = 12'h5C0; mem[1] = 12'h704; mem[2] = 12'h3C1; mem[3] = 12'h000;
    mem[4] = 12'h806; mem[5] = 12'h3C1; mem[6] = 12'h5C2; mem[7] = 12'h70A;
    mem[8] = 12'h80A; mem[9] = 12'h3C3; mem[10] = 12'h000;
    mem[8'hC1] = 12'h111; mem[8'hC2] = 12'h800; mem[8'hC3] = 12'h222;
    runProgram("R5");
    check(mem[8'hC1] == 12'h111, "R5", "zero branches taken", mem[8'hC1], 12'h111);
    check(mem[8'hC3] == 12'h800, "R6", "negative falls through", mem[8'hC3], 12'h800);

    // R4 / R8: unconditional branch and no-op opcodes
    clearMem();
    mem[0] = 12'h5C0; mem[1] = 12'h604; mem[2] = 12'h3C1; mem[3] = 12'h000;
    mem[4] = 12'h4FF; mem[5] = 12'h9C1; mem[6] = 12'hFC1; mem[7] = 12'h3C2;
    mem[8] = 12'h000;
    mem[8'hC0] = 12'h123; mem[8'hC1] = 12'h333;
    runProgram("R8");
    check(mem[8'hC1] == 12'h333, "R8", "no-op touched memory", mem[8'hC1], 12'h333);
    check(mem[8'hC2] == 12'h123, "R8", "ACC after no-ops", mem[8'hC2], 12'h123);

    // R7: rerun after halt without reloading; reset restarts at 0
    mem[8'hC2] = 12'h000;
    runProgram("R7");
    check(mem[8'hC2] == 12'h123, "R7", "restart result", mem[8'hC2], 12'h123);

    // R3 and the rest: random straight-line and forward-branch programs
    for (int t = 0; t < 40; t++) begin
      randProgram();
      runProgram("R3");
    end

    summary();
    $finish;
  end
endmodule